// File: doc/BRIEF.md
# GPIO Interrupt Channel Trigger Controller

This block selects a small number of interrupt channels out of a wide GPIO input bus. Each channel picks one pin with an 8-bit selector. The chosen pin passes through a two-flop synchroniser and an optional glitch filter. A trigger detector then turns it into a registered interrupt line. The detector has five behaviours: high level, low level, rising edge, falling edge, and any transition.

Software programs the channels through a small word-addressed register window, 16 bytes in size. The trigger word holds three per-channel bit groups. The edge group chooses edge mode (1) or level mode (0). The polarity group chooses low/falling (1) or high/rising (0). The any-transition group overrides both of the other groups while it is set. The pin selectors are packed four to a word. The filter word holds one 4-bit length field per channel. Each `irq_out` bit is meant to be routed to an upstream interrupt controller.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every register reads zero. All channels then act as level-high on pin 0 with no filter, so every `irq_out` bit follows `gpio_in[0]`.
- R2: Word address 0x0 is the trigger word. Channel x has its edge-mode bit at x, its any-transition bit at 8+x and its low/falling bit at 16+x. Bits 31:24 ignore writes and read 0. `reg_rdata` shows the word at `reg_addr` one clock after the address is applied.
- R3: Pin selectors are 8 bits wide. Channels 0–3 sit at address 0x4 and channels 4–7 at 0x8. Channel x is at bit offset (x mod 4)*8.
- R4: A selector value of NUM_PINS (100) or more selects no pin, and the channel sees a constant 0.
- R5: In level mode, `irq_out[x]` equals the filtered pin level, inverted when the low bit is set.
- R6: In edge mode, each qualifying transition gives a single-cycle pulse on `irq_out[x]`. The rising or falling direction comes from the low bit.
- R7: While the any-transition bit of a channel is set, the channel pulses for one cycle on both rising and falling transitions. Its edge and low bits have no effect during that time.
- R8: Clearing the any-transition bit returns the channel to the behaviour set by its edge and low bits.
- R9: The filter field of channel x is 4 bits at offset 4*x of address 0xC. A value N > 0 accepts a pin change only after the new level has been present for 4*N consecutive synchronised cycles. Shorter pulses are discarded. The output then reacts 4*N+3 cycles after the pin changes.
- R10: With filter 0, the output reacts exactly 4 clock cycles after a pin change (sync, filter stage, output register).
- R11: Channels are independent. Each one uses only its own pin, mode and filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| gpio_in | input | 100 | Asynchronous GPIO inputs |
| irq_out | output | 8 | One interrupt line per channel |

## Verification
The bench sets a channel to falling-edge mode and then sets its any-transition bit. A design that lets the edge or low bits win would stay silent on the rising edge. After the any-transition bit is cleared, a stale override would keep pulsing on both edges. An out-of-range selector paired with low polarity must hold its line high; a design that wraps the index would follow some real pin instead. Filter checks sample one cycle before and at the 4*N+3 boundary, and apply a seven-cycle glitch against a length of eight. An off-by-one in the qualification counter would shift the output or let the glitch through.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SEL_W = 8;
  localparam int FLT_W = 4;

  typedef struct packed {
    logic             edge_md;
    logic             any_edge;
    logic             low_pol;
    logic [SEL_W-1:0] sel;
    logic [FLT_W-1:0] flt;
  } ch_cfg_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ch_cfg_t           cfg [NUM_CH]
);
  localparam int SEL_PER_WORD = DATA_W / SEL_W;
  localparam int GRP_W        = 8;

  logic [NUM_CH-1:0] edge_q, any_q, low_q;
  logic [SEL_W-1:0]  sel_q [NUM_CH];
  logic [FLT_W-1:0]  flt_q [NUM_CH];
  logic [1:0]        word;
  logic [DATA_W-1:0] w_trig, w_sel0, w_sel1, w_flt;

  assign word = addr[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= '0;
      any_q  <= '0;
      low_q  <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        sel_q[i] <= '0;
        flt_q[i] <= '0;
      end
    end else if (we) begin
      case (word)
        2'd0: begin
          edge_q <= wdata[0 +: NUM_CH];
          any_q  <= wdata[GRP_W +: NUM_CH];
          low_q  <= wdata[2*GRP_W +: NUM_CH];
        end
        2'd1: for (int i = 0; i < SEL_PER_WORD; i++)
                if (i < NUM_CH) sel_q[i] <= wdata[SEL_W*i +: SEL_W];
        2'd2: for (int i = 0; i < SEL_PER_WORD; i++)
                if (i + SEL_PER_WORD < NUM_CH)
                  sel_q[i+SEL_PER_WORD] <= wdata[SEL_W*i +: SEL_W];
        default: for (int i = 0; i < NUM_CH; i++)
                   flt_q[i] <= wdata[FLT_W*i +: FLT_W];
      endcase
    end
  end

  always_comb begin
    w_trig = '0;
    w_sel0 = '0;
    w_sel1 = '0;
    w_flt  = '0;
    w_trig[0 +: NUM_CH]       = edge_q;
    w_trig[GRP_W +: NUM_CH]   = any_q;
    w_trig[2*GRP_W +: NUM_CH] = low_q;
    for (int i = 0; i < SEL_PER_WORD; i++) begin
      if (i < NUM_CH) w_sel0[SEL_W*i +: SEL_W] = sel_q[i];
      if (i + SEL_PER_WORD < NUM_CH)
        w_sel1[SEL_W*i +: SEL_W] = sel_q[i+SEL_PER_WORD];
    end
    for (int i = 0; i < NUM_CH; i++) w_flt[FLT_W*i +: FLT_W] = flt_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (word)
        2'd0:    rdata <= w_trig;
        2'd1:    rdata <= w_sel0;
        2'd2:    rdata <= w_sel1;
        default: rdata <= w_flt;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    assign cfg[g] = '{edge_md: edge_q[g], any_edge: any_q[g], low_pol: low_q[g],
                      sel: sel_q[g], flt: flt_q[g]};
  end

  // R2
  trig_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && word == 2'd0) |=> (any_q == $past(wdata[GRP_W +: NUM_CH]) &&
                              low_q == $past(wdata[2*GRP_W +: NUM_CH])));
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int FLT_W    = 4,
  parameter int FLT_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [FLT_W-1:0] nsel,
  output logic             dout
);
  localparam int MAX_CNT = (2**FLT_W - 1) * FLT_UNIT;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(nsel) * CNT_W'(FLT_UNIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= 1'b0;
      cnt_q <= '0;
    end else if (nsel == '0) begin
      dout  <= din;
      cnt_q <= '0;
    end else if (din == dout) begin
      cnt_q <= '0;
    end else if (cnt_q == limit - 1'b1) begin
      dout  <= din;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  flt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == $past(din)));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q < limit || $past(nsel) != nsel));
endmodule

// File: rtl/gpio_irq_channel.sv
module gpio_irq_channel
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 100,
  parameter int FLT_UNIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] gpio,
  input  ch_cfg_t             cfg,
  output logic                irq
);
  logic pin_lvl, meta_q, sync_q, lvl, prev_q;
  logic sel_oob;

  assign sel_oob = (int'(cfg.sel) >= NUM_PINS);

  always_comb begin
    pin_lvl = 1'b0;
    for (int p = 0; p < NUM_PINS; p++)
      if (cfg.sel == SEL_W'(p)) pin_lvl = gpio[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin_lvl;
      sync_q <= meta_q;
    end
  end

  gpio_irq_filter #(.FLT_W(FLT_W), .FLT_UNIT(FLT_UNIT)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_q),
    .nsel (cfg.flt),
    .dout (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (cfg.any_edge)     irq <= lvl ^ prev_q;
      else if (cfg.edge_md) irq <= cfg.low_pol ? (prev_q & ~lvl) : (lvl & ~prev_q);
      else                  irq <= lvl ^ cfg.low_pol;
    end
  end

  // R4
  oob_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_oob && $past(sel_oob) && $past(sel_oob, 2)) |-> !sync_q);
  // R6
  edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && cfg.edge_md && !cfg.any_edge) |=> (!irq || !$stable(cfg)));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 100,
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int FLT_UNIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_CH-1:0]   irq_out
);
  ch_cfg_t cfg [NUM_CH];

  gpio_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gpio_irq_channel #(.NUM_PINS(NUM_PINS), .FLT_UNIT(FLT_UNIT)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .gpio (gpio_in),
      .cfg  (cfg[c]),
      .irq  (irq_out[c])
    );
  end
endmodule

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [99:0] gpio_in;
  logic [7:0]  irq_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct {
    int         cyc;
    logic [7:0] mask;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_irq_router u_gpio_irq_router (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_in(gpio_in), .irq_out(irq_out)
  );

  // monitor: pops expected items in their cycle
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (it.cyc < cyc) begin
        errors++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", it.req, it.cyc, cyc);
      end else if ((irq_out & it.mask) !== it.exp) begin
        errors++;
        $display("FAIL %s: cycle %0d irq_out&%h = %h, expected %h",
                 it.req, cyc, it.mask, irq_out & it.mask, it.exp);
      end
    end
  end

  task automatic push(input int at, input logic [7:0] mask, input logic [7:0] exp,
                      input string req);
    item_t it;
    it.cyc = at; it.mask = mask; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  task automatic check_now(input logic [7:0] exp, input string req);
    checks++;
    if (irq_out !== exp) begin
      errors++;
      $display("FAIL %s: irq_out = %h, expected %h", req, irq_out, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read %h = %h, expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; gpio_in = '0;
    repeat (5) @(negedge clk);
    check_now(8'h00, "R1 reset output");
    rst = 1'b0;
    rd(4'h0, 32'h0, "R1 trig reset");
    rd(4'h4, 32'h0, "R1 sel0 reset");
    rd(4'h8, 32'h0, "R1 sel1 reset");
    rd(4'hC, 32'h0, "R1 filter reset");

    // R1: default level-high on pin 0 everywhere, R10 latency 4
    @(negedge clk); gpio_in[0] = 1'b1; c = cyc;
    push(c+3, 8'hFF, 8'h00, "R10 not before 4 cycles");
    push(c+4, 8'hFF, 8'hFF, "R1 default pin0 level");
    drain();
    gpio_in[0] = 1'b0; c = cyc;
    push(c+4, 8'hFF, 8'h00, "R1 default pin0 low");
    drain();

    // R3 / R4 selectors, R2 trigger word
    wr(4'h4, {8'd30, 8'd20, 8'd10, 8'd5});
    wr(4'h8, {8'd99, 8'd120, 8'd50, 8'd40});
    wr(4'h0, 32'hFF6A_302C);
    rd(4'h4, {8'd30, 8'd20, 8'd10, 8'd5}, "R3 sel word 0");
    rd(4'h8, {8'd99, 8'd120, 8'd50, 8'd40}, "R3 sel word 1");
    rd(4'h0, 32'h006A_302C, "R2 trig readback");
    settle();
    check_now(8'h42, "R4 R5 idle levels (oob low-pol high)");

    // rise on all selected pins: R5 R6 R7 R11
    gpio_in[5] = 1; gpio_in[10] = 1; gpio_in[20] = 1; gpio_in[30] = 1;
    gpio_in[40] = 1; gpio_in[50] = 1; gpio_in[99] = 1; c = cyc;
    push(c+3, 8'hFF, 8'h42, "R10 rise latency");
    push(c+4, 8'hFF, 8'hF5, "R11 R7 rise mix");
    push(c+5, 8'hFF, 8'hC1, "R6 pulse one cycle");
    drain();

    // fall on all: R6 falling, R7 double-edge on fall
    gpio_in = '0; c = cyc;
    push(c+4, 8'hFF, 8'h7A, "R7 R6 fall mix");
    push(c+5, 8'hFF, 8'h42, "R6 fall pulse ends");
    drain();

    // R8: clear any-transition bits
    wr(4'h0, 32'h006A_002C);
    settle();
    check_now(8'h42, "R8 idle after clear");
    gpio_in[40] = 1; gpio_in[50] = 1; c = cyc;
    push(c+4, 8'h30, 8'h10, "R8 ch4 level, ch5 no rise pulse");
    push(c+5, 8'h30, 8'h10, "R8 ch4 level held");
    drain();
    gpio_in[50] = 0; c = cyc;
    push(c+4, 8'h30, 8'h30, "R8 ch5 falling pulse");
    push(c+5, 8'h30, 8'h10, "R8 ch5 pulse ends");
    drain();
    gpio_in[40] = 0;
    settle();

    // R9 filters: ch0 N=2, ch7 N=1
    wr(4'hC, 32'h1000_0002);
    rd(4'hC, 32'h1000_0002, "R9 filter readback");
    settle();
    gpio_in[5] = 1; gpio_in[99] = 1; c = cyc;
    push(c+6,  8'h81, 8'h00, "R9 N=1 not before 7");
    push(c+7,  8'h81, 8'h80, "R9 N=1 at 7");
    push(c+10, 8'h81, 8'h80, "R9 N=2 not before 11");
    push(c+11, 8'h81, 8'h81, "R9 N=2 at 11");
    drain();

    // R9 glitch of 7 cycles against a length of 8
    gpio_in[5] = 0; c = cyc;
    repeat (7) @(negedge clk);
    gpio_in[5] = 1;
    push(c+8,  8'h81, 8'h81, "R9 glitch rejected");
    push(c+12, 8'h81, 8'h81, "R9 glitch rejected");
    push(c+16, 8'h81, 8'h81, "R9 glitch rejected");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule